// File: doc/BRIEF.md
# Hibernate entry and wakeup controller

This block holds one 32-bit retained power-mode word and runs the sequence that puts a chip into a hibernate state. Firmware cannot drop into hibernate with a single stray store. The word must carry a fixed unlock byte, and the same value must be written three times in a row. Each identical write moves the block one stage along. The first raises a warning to peripherals that a freeze is on its way. The second freezes the IOs. The third requests hibernate.

While the block is hibernating, wake sources are watched through per-source masks: an RTC alarm, a watchdog interrupt and four wake pins. Each wake pin has its own polarity bit. A wake drops the hibernate request and gives a one-cycle wake pulse. The IO freeze, the FREEZE field and an 8-bit firmware token are kept until firmware clears FREEZE. While FREEZE is set, the internal reset input is ignored. Only the external reset clears the token.

Top module: `hib_ctrl`

## Requirements
- R1: After the external reset `xrst`, the read word is 0x00000000 and `freeze_warn`, `io_freeze`, `hib_req` and `wake_pulse` are all low.
- R2: A write stores `wdata` with reserved bits 16, 28 and 29 forced to zero. `rdata` shows the stored word from the cycle after the write. The field positions are:
  - token: bits 7:0
  - unlock: bits 15:8
  - FREEZE: bit 17
  - RTC mask: bit 18
  - WDT mask: bit 19
  - pin polarity: bits 23:20
  - pin mask: bits 27:24
  - disable: bit 30
  - HIBERNATE: bit 31
- R3: `freeze_warn` equals the stored FREEZE bit (bit 17). It rises in the cycle after the first write that sets FREEZE, whatever the unlock byte holds.
- R4: `io_freeze` rises after the second consecutive identical write, but only if the word has unlock byte 0x3A, FREEZE=1 and HIBERNATE=1. With any other unlock byte, `io_freeze` and `hib_req` never assert.
- R5: `hib_req` rises after the third consecutive identical write of a word that meets R4 and has the disable bit (bit 30) at 0. A read after that write returns the written word.
- R6: A write that differs from the stored word restarts the count, and that write counts as the first.
- R7: With the disable bit set, `hib_req` never asserts. `io_freeze` still follows R4.
- R8: While `hib_req` is high, a wake is caused by any of:
  - an RTC alarm with bit 18 set;
  - a watchdog interrupt with bit 19 set;
  - a pin whose mask bit is set and whose level equals its polarity bit.

  On a wake, `hib_req` falls and `wake_pulse` is high for exactly one cycle. Unmasked sources have no effect.
- R9: After a wake, `io_freeze`, FREEZE and the token stay unchanged until a write clears FREEZE.
- R10: `int_rst` is ignored while FREEZE is 1. While FREEZE is 0, `int_rst` clears every field except the token and restarts the sequence. Only `xrst` clears the token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| xrst | input | 1 | External reset, synchronous, active high, clears everything |
| int_rst | input | 1 | Internal reset, synchronous, active high, ignored while frozen |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Stored register word |
| rtc_alarm | input | 1 | RTC alarm wake source |
| wdt_irq | input | 1 | Watchdog interrupt wake source |
| wake_pin | input | 4 | Wake pin levels |
| freeze_warn | output | 1 | Warning to peripherals that a freeze is coming |
| io_freeze | output | 1 | IO freeze command |
| hib_req | output | 1 | Hibernate request |
| wake_pulse | output | 1 | One-cycle pulse on wakeup |

## Verification
The bench builds the block with its default parameters: four wake pins and an unlock key of 0x3A. With only four pins, every pin mask, polarity and level combination can be swept in full, 4096 hibernate entries with a wake check after each. All sixteen combinations of the RTC and watchdog masks and levels are swept as well. The staged write count is checked separately against:
- a wrong unlock byte,
- a broken sequence,
- the disable bit,
- internal reset while frozen and while not frozen.

// File: rtl/hib_pkg.sv
package hib_pkg;

    localparam int DATA_W   = 32;
    localparam int TOKEN_W  = 8;
    localparam int KEY_W    = 8;
    localparam int NUM_PINS = 4;

    localparam logic [KEY_W-1:0]  UNLOCK_DEFAULT = 8'h3A;
    localparam logic [DATA_W-1:0] RSV_MASK       = 32'h3001_0000;

    typedef struct packed {
        logic                hib;
        logic                hib_dis;
        logic [1:0]          rsv_hi;
        logic [NUM_PINS-1:0] pin_mask;
        logic [NUM_PINS-1:0] pin_pol;
        logic                mask_wdt;
        logic                mask_rtc;
        logic                freeze;
        logic                rsv_lo;
        logic [KEY_W-1:0]    unlock;
        logic [TOKEN_W-1:0]  token;
    } hib_reg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ONE,
        ST_TWO,
        ST_SLEEP,
        ST_WOKE
    } seq_state_t;

    function automatic hib_reg_t bus_to_reg(input logic [DATA_W-1:0] w);
        return hib_reg_t'(w & ~RSV_MASK);
    endfunction

    function automatic hib_reg_t keep_token(input hib_reg_t r);
        hib_reg_t t;
        t       = '0;
        t.token = r.token;
        return t;
    endfunction

    function automatic logic pin_hit(input logic m, input logic p, input logic lvl);
        return m & ~(p ^ lvl);
    endfunction

endpackage

// File: rtl/hib_regfile.sv
module hib_regfile
    import hib_pkg::*;
(
    input  logic              clk,
    input  logic              xrst,
    input  logic              int_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output hib_reg_t          reg_q,
    output logic              soft_clr,
    output logic              wr_same
);

    hib_reg_t wr_val;

    assign wr_val   = bus_to_reg(wdata);
    assign soft_clr = int_rst && !reg_q.freeze;
    assign wr_same  = wr_en && (wr_val == reg_q);

    always_ff @(posedge clk) begin
        if (xrst) begin
            reg_q <= '0;
        end else if (soft_clr) begin
            reg_q <= keep_token(reg_q);
        end else if (wr_en) begin
            reg_q <= wr_val;
        end
    end

endmodule

// File: rtl/hib_wake.sv
module hib_wake #(
    parameter int NPIN = 4
) (
    input  logic            mask_rtc,
    input  logic            mask_wdt,
    input  logic [NPIN-1:0] pin_mask,
    input  logic [NPIN-1:0] pin_pol,
    input  logic            rtc_alarm,
    input  logic            wdt_irq,
    input  logic [NPIN-1:0] wake_pin,
    output logic            wake_src
);

    logic [NPIN-1:0] pin_fire;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign pin_fire[g] = hib_pkg::pin_hit(pin_mask[g], pin_pol[g], wake_pin[g]);
    end

    assign wake_src = (mask_rtc & rtc_alarm) | (mask_wdt & wdt_irq) | (|pin_fire);

endmodule

// File: rtl/hib_seq.sv
module hib_seq
    import hib_pkg::*;
#(
    parameter logic [KEY_W-1:0] UNLOCK_KEY = UNLOCK_DEFAULT
) (
    input  logic             clk,
    input  logic             xrst,
    input  logic             soft_clr,
    input  logic             wr_en,
    input  logic             wr_same,
    input  logic [KEY_W-1:0] unlock,
    input  logic             freeze,
    input  logic             hib,
    input  logic             hib_dis,
    input  logic             wake_src,
    output logic             io_freeze,
    output logic             hib_req,
    output logic             wake_pulse
);

    seq_state_t state_q, state_d;
    logic       io_cond;
    logic       do_wake;

    assign io_cond = (unlock == UNLOCK_KEY) && freeze && hib;
    assign do_wake = (state_q == ST_SLEEP) && wake_src;

    always_comb begin
        state_d = state_q;
        if (soft_clr) begin
            state_d = ST_IDLE;
        end else if (do_wake) begin
            state_d = ST_WOKE;
        end else if (wr_en) begin
            if (wr_same && state_q != ST_IDLE) begin
                case (state_q)
                    ST_ONE:  state_d = ST_TWO;
                    ST_TWO:  state_d = (io_cond && !hib_dis) ? ST_SLEEP : ST_TWO;
                    default: state_d = state_q;
                endcase
            end else begin
                state_d = ST_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (xrst) begin
            state_q    <= ST_IDLE;
            wake_pulse <= 1'b0;
        end else begin
            state_q    <= state_d;
            wake_pulse <= do_wake && !soft_clr;
        end
    end

    assign io_freeze = io_cond &&
                       (state_q == ST_TWO || state_q == ST_SLEEP || state_q == ST_WOKE);
    assign hib_req   = (state_q == ST_SLEEP);

endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
    import hib_pkg::*;
#(
    parameter logic [KEY_W-1:0] UNLOCK_KEY = UNLOCK_DEFAULT
) (
    input  logic                clk,
    input  logic                xrst,
    input  logic                int_rst,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                rtc_alarm,
    input  logic                wdt_irq,
    input  logic [NUM_PINS-1:0] wake_pin,
    output logic                freeze_warn,
    output logic                io_freeze,
    output logic                hib_req,
    output logic                wake_pulse
);

    hib_reg_t reg_q;
    logic     soft_clr;
    logic     wr_same;
    logic     wake_src;

    hib_regfile u_regs (
        .clk      (clk),
        .xrst     (xrst),
        .int_rst  (int_rst),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .reg_q    (reg_q),
        .soft_clr (soft_clr),
        .wr_same  (wr_same)
    );

    hib_wake #(.NPIN(NUM_PINS)) u_wake (
        .mask_rtc  (reg_q.mask_rtc),
        .mask_wdt  (reg_q.mask_wdt),
        .pin_mask  (reg_q.pin_mask),
        .pin_pol   (reg_q.pin_pol),
        .rtc_alarm (rtc_alarm),
        .wdt_irq   (wdt_irq),
        .wake_pin  (wake_pin),
        .wake_src  (wake_src)
    );

    hib_seq #(.UNLOCK_KEY(UNLOCK_KEY)) u_seq (
        .clk        (clk),
        .xrst       (xrst),
        .soft_clr   (soft_clr),
        .wr_en      (wr_en),
        .wr_same    (wr_same),
        .unlock     (reg_q.unlock),
        .freeze     (reg_q.freeze),
        .hib        (reg_q.hib),
        .hib_dis    (reg_q.hib_dis),
        .wake_src   (wake_src),
        .io_freeze  (io_freeze),
        .hib_req    (hib_req),
        .wake_pulse (wake_pulse)
    );

    assign rdata       = reg_q;
    assign freeze_warn = reg_q.freeze;

endmodule

// File: rtl/hib_ctrl_chk.sv
module hib_ctrl_chk #(
    parameter logic [7:0] UNLOCK_KEY = 8'h3A
) (
    input logic        clk,
    input logic        xrst,
    input logic        int_rst,
    input logic        wr_en,
    input logic        wr_freeze,
    input logic [31:0] rdata,
    input logic        freeze_warn,
    input logic        io_freeze,
    input logic        hib_req,
    input logic        wake_pulse
);

    p_warn_follows_r3: assert property (@(posedge clk) disable iff (xrst)
        (wr_en && !int_rst) |=> (freeze_warn == $past(wr_freeze)));

    p_io_needs_key_r4: assert property (@(posedge clk) disable iff (xrst)
        io_freeze |-> (rdata[15:8] == UNLOCK_KEY && rdata[31] && rdata[17]));

    p_req_needs_io_r5: assert property (@(posedge clk) disable iff (xrst)
        hib_req |-> io_freeze);

    p_io_on_write_r6: assert property (@(posedge clk) disable iff (xrst)
        $rose(io_freeze) |-> $past(wr_en));

    p_disable_blocks_r7: assert property (@(posedge clk) disable iff (xrst)
        hib_req |-> !rdata[30]);

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (xrst)
        wake_pulse |=> !wake_pulse);

    p_pulse_drop_r8: assert property (@(posedge clk) disable iff (xrst)
        $rose(wake_pulse) |-> ($past(hib_req) && !hib_req));

    p_frozen_hold_r10: assert property (@(posedge clk) disable iff (xrst)
        (int_rst && freeze_warn && !wr_en) |=> $stable(rdata));

endmodule

bind hib_ctrl hib_ctrl_chk #(.UNLOCK_KEY(UNLOCK_KEY)) u_chk (
    .clk         (clk),
    .xrst        (xrst),
    .int_rst     (int_rst),
    .wr_en       (wr_en),
    .wr_freeze   (wdata[17]),
    .rdata       (rdata),
    .freeze_warn (freeze_warn),
    .io_freeze   (io_freeze),
    .hib_req     (hib_req),
    .wake_pulse  (wake_pulse)
);

// File: tb/hib_ctrl_tb_top.sv
module hib_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        xrst = 1'b1;
    logic        int_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rtc_alarm = 1'b0;
    logic        wdt_irq = 1'b0;
    logic [3:0]  wake_pin = '0;
    logic        freeze_warn, io_freeze, hib_req, wake_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    hib_ctrl dut_i (
        .clk(clk), .xrst(xrst), .int_rst(int_rst), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .rtc_alarm(rtc_alarm), .wdt_irq(wdt_irq), .wake_pin(wake_pin),
        .freeze_warn(freeze_warn), .io_freeze(io_freeze), .hib_req(hib_req),
        .wake_pulse(wake_pulse)
    );

    function automatic logic [31:0] mk(input logic hib, input logic dis, input logic [3:0] pmask,
                                       input logic [3:0] ppol, input logic mw, input logic mr,
                                       input logic frz, input logic [7:0] key, input logic [7:0] tok);
        return ({31'd0, hib} << 31) | ({31'd0, dis} << 30) | ({28'd0, pmask} << 24) |
               ({28'd0, ppol} << 20) | ({31'd0, mw} << 19) | ({31'd0, mr} << 18) |
               ({31'd0, frz} << 17) | ({24'd0, key} << 8) | {24'd0, tok};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic outs(input string tag, input logic w, input logic io, input logic rq);
        chk({tag, " warn"}, {31'd0, freeze_warn}, {31'd0, w});
        chk({tag, " io"},   {31'd0, io_freeze},   {31'd0, io});
        chk({tag, " req"},  {31'd0, hib_req},     {31'd0, rq});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] g;
        logic [31:0] w;
        logic        e;
        repeat (3) @(negedge clk);
        xrst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", rdata, 32'h0);
        outs("R1", 1'b0, 1'b0, 1'b0);
        chk("R1 pulse", {31'd0, wake_pulse}, 32'h0);

        // R2 reserved bits cleared
        wr(32'hFFFF_FFFF);
        chk("R2 rdata", rdata, 32'hCFFE_FFFF);
        wr(32'h0000_1234);
        chk("R2 rdata2", rdata, 32'h0000_1234);

        // R3 warning with wrong key, R4 no freeze with wrong key
        w = mk(1, 0, 0, 0, 0, 0, 1, 8'h55, 8'h01);
        wr(w);
        outs("R3 w1", 1'b1, 1'b0, 1'b0);
        wr(w);
        outs("R4 badkey w2", 1'b1, 1'b0, 1'b0);
        wr(w);
        outs("R4 badkey w3", 1'b1, 1'b0, 1'b0);
        wr(32'h0);
        outs("R3 cleared", 1'b0, 1'b0, 1'b0);

        // R4 / R5 staged entry
        g = mk(1, 0, 0, 0, 0, 0, 1, 8'h3A, 8'hA5);
        wr(g);
        outs("R4 w1", 1'b1, 1'b0, 1'b0);
        wr(g);
        outs("R4 w2", 1'b1, 1'b1, 1'b0);
        wr(g);
        outs("R5 w3", 1'b1, 1'b1, 1'b1);
        chk("R5 settled read", rdata, g);
        wr(32'h0);
        outs("R5 exit", 1'b0, 1'b0, 1'b0);

        // R6 broken sequence
        wr(g);
        wr(g);
        wr(g ^ 32'h1);
        outs("R6 restart", 1'b1, 1'b0, 1'b0);
        wr(g ^ 32'h1);
        outs("R6 second", 1'b1, 1'b1, 1'b0);
        wr(g ^ 32'h1);
        outs("R6 third", 1'b1, 1'b1, 1'b1);
        wr(32'h0);

        // R7 disable
        w = mk(1, 1, 0, 0, 0, 0, 1, 8'h3A, 8'h07);
        wr(w);
        wr(w);
        outs("R7 w2", 1'b1, 1'b1, 1'b0);
        wr(w);
        outs("R7 w3", 1'b1, 1'b1, 1'b0);
        wr(w);
        outs("R7 w4", 1'b1, 1'b1, 1'b0);
        wr(32'h0);

        // R8 / R9 pin sweep
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 16; p++) begin
                for (int v = 0; v < 16; v++) begin
                    w = mk(1, 0, 4'(m), 4'(p), 0, 0, 1, 8'h3A, {4'(m), 4'(p)});
                    e = |(4'(m) & ~(4'(p) ^ 4'(v)));
                    wake_pin = 4'(v);
                    wr(w);
                    wr(w);
                    wr(w);
                    chk("R5 sweep req", {31'd0, hib_req}, 32'h1);
                    @(negedge clk);
                    chk("R8 pin req", {31'd0, hib_req}, {31'd0, ~e});
                    chk("R8 pin pulse", {31'd0, wake_pulse}, {31'd0, e});
                    if (e) begin
                        @(negedge clk);
                        chk("R8 pulse width", {31'd0, wake_pulse}, 32'h0);
                        chk("R9 io held", {31'd0, io_freeze}, 32'h1);
                        chk("R9 word held", rdata, w);
                    end
                    wake_pin = 4'h0;
                    wr(32'h0);
                    if (e) chk("R9 io released", {31'd0, io_freeze}, 32'h0);
                end
            end
        end

        // R8 rtc / wdt sweep
        for (int c = 0; c < 16; c++) begin
            w = mk(1, 0, 0, 0, c[1], c[0], 1, 8'h3A, 8'h3C);
            e = (c[0] & c[2]) | (c[1] & c[3]);
            rtc_alarm = c[2];
            wdt_irq   = c[3];
            wr(w);
            wr(w);
            wr(w);
            @(negedge clk);
            chk("R8 timer req", {31'd0, hib_req}, {31'd0, ~e});
            chk("R8 timer pulse", {31'd0, wake_pulse}, {31'd0, e});
            rtc_alarm = 1'b0;
            wdt_irq   = 1'b0;
            wr(32'h0);
        end

        // R10 internal reset while frozen is ignored
        wr(g);
        wr(g);
        wr(g);
        @(negedge clk);
        int_rst = 1'b1;
        @(negedge clk);
        int_rst = 1'b0;
        chk("R10 frozen word", rdata, g);
        chk("R10 frozen req", {31'd0, hib_req}, 32'h1);

        // R10 internal reset while not frozen keeps token
        wr(32'h0000_3A5C);
        @(negedge clk);
        int_rst = 1'b1;
        @(negedge clk);
        int_rst = 1'b0;
        chk("R10 token kept", rdata, 32'h0000_005C);
        outs("R10 soft", 1'b0, 1'b0, 1'b0);

        // R10 / R1 external reset clears token
        xrst = 1'b1;
        @(negedge clk);
        xrst = 1'b0;
        @(negedge clk);
        chk("R10 xrst token", rdata, 32'h0);
        outs("R1 after xrst", 1'b0, 1'b0, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule